// File: doc/BRIEF.md
# Vector Extension CSR Unit

This block owns the architectural control and status state of a vector unit: the restart element index, the fixed-point saturation flag and rounding mode, the active vector length, the vector type word and a constant that reports the vector register size in bytes. A core's CSR pipeline presents one read or write request per cycle with a 12-bit address. The block answers one cycle later with read data or an illegal-instruction flag, and updates its state on the same edge that captures the request.

The block also keeps the two-bit vector context status field. The field is visible at bits [24:23] of both the machine and the supervisor status views. While the field is Off, the vector-length, vector-type, byte-length and start-index registers cannot be accessed, and any vector instruction issue is rejected. When the core has no floating-point unit, a floating-point control/status view is also served here, so the fixed-point fields can be read and written through a second address. Vector length and type are user read-only. A separate update port loads them together when a configuration instruction retires.

Top module: `vec_csr_unit`

## Requirements
- R1: After reset the context status is Off (0). Start index, saturation flag, rounding mode and vector length read as 0, and the vector type reads with only bit XLEN-1 set.
- R2: Addresses 0x008 (start index), 0x009 (saturation flag, 1 bit) and 0x00A (rounding mode, 2 bits) are read-write. A read returns the stored value with all upper bits zero. The start index keeps only its low log2(VLEN) bits.
- R3: A CSR write to 0xC20 (vector length), 0xC21 (vector type) or 0xC22 (byte length) is reported illegal and changes no state.
- R4: A legal read of 0xC22 returns VLEN/8.
- R5: The context status field sits at bits [24:23] of address 0x300 (machine view) and address 0x100 (supervisor view). A write through either view sets the field, and both views read the same value.
- R6: While the status is Off (0), any access to 0x008, 0xC20, 0xC21 or 0xC22 is illegal and leaves all state unchanged. In the same cycle, `issue_illegal` follows `issue_valid`. In any other status, `issue_illegal` stays low.
- R7: With no floating-point unit, address 0x003 mirrors the fixed-point fields: rounding mode at bits [10:9] and saturation flag at bit 8, other bits zero. A write through either view is seen through the other.
- R8: The status encodings are 0 Off, 1 Initial, 2 Clean and 3 Dirty. If the status is not Off, a successful write to 0x008, 0x009, 0x00A or 0x003, or an accepted configuration update, sets it to Dirty (3). A status-view write in the same cycle takes precedence over this. While the status is Off, it stays Off.
- R9: A configuration update loads the vector length and vector type together, and they are visible from the next cycle. The update is ignored while the status is Off. A simultaneous CSR write to another register also takes effect.
- R10: A request to an unimplemented address in 0x008–0x00F or 0xC20–0xC2F returns the illegal flag with zero data. A request outside all served addresses produces no response.
- R11: The response (`rsp_valid`, `rsp_illegal`, `rsp_rdata`) appears the cycle after the request. A write's response carries the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CSR request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 12 | CSR address |
| req_wdata | input | XLEN | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_illegal | output | 1 | Request was illegal |
| rsp_rdata | output | XLEN | Read data (old value on writes, zero if illegal) |
| issue_valid | input | 1 | A vector instruction is issuing |
| issue_illegal | output | 1 | Issue rejected because vector state is Off |
| cfg_valid | input | 1 | Configuration update strobe |
| cfg_vl | input | log2(VLEN)+1 | New vector length |
| cfg_vtype | input | XLEN | New vector type word |
| ctx_status | output | 2 | Current context status field |

## Verification
CSR responses arrive exactly one rising edge after a request. State changes, including the context status, are visible at the falling edge after that same rising edge. `issue_illegal` is combinational and is valid in the cycle of `issue_valid`. The bench's driver places each request at a falling edge and queues the response it expects at that moment. The monitor compares the head of the queue 1 ns after each rising edge that carries `rsp_valid`, so any extra, missing or late response shows up as a mismatch. Status and issue checks are sampled at falling edges, one cycle after the stimulus that should change them.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;

    localparam logic [11:0] A_VSTART  = 12'h008;
    localparam logic [11:0] A_VXSAT   = 12'h009;
    localparam logic [11:0] A_VXRM    = 12'h00A;
    localparam logic [11:0] A_VL      = 12'hC20;
    localparam logic [11:0] A_VTYPE   = 12'hC21;
    localparam logic [11:0] A_VLENB   = 12'hC22;
    localparam logic [11:0] A_FCSR    = 12'h003;
    localparam logic [11:0] A_MSTATUS = 12'h300;
    localparam logic [11:0] A_SSTATUS = 12'h100;

    localparam int CTX_LO    = 23;
    localparam int CTX_HI    = 24;
    localparam int FX_SAT    = 8;
    localparam int FX_RM_LO  = 9;
    localparam int FX_RM_HI  = 10;

    typedef enum logic [1:0] {
        CTX_OFF   = 2'd0,
        CTX_INIT  = 2'd1,
        CTX_CLEAN = 2'd2,
        CTX_DIRTY = 2'd3
    } ctx_e;

    typedef enum logic [3:0] {
        K_NONE, K_VSTART, K_VXSAT, K_VXRM, K_VL, K_VTYPE,
        K_VLENB, K_FCSR, K_MSTATUS, K_SSTATUS, K_BAD
    } csr_kind_e;

    typedef struct packed {
        csr_kind_e kind;
        logic      hit;
        logic      illegal;
        logic      wr_en;
    } dec_t;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic logic in_vec_range(input logic [11:0] a);
        return (a[11:3] == 9'h001) || (a[11:4] == 8'hC2);
    endfunction

    function automatic logic gated_by_ctx(input csr_kind_e k);
        return (k == K_VSTART) || (k == K_VL) || (k == K_VTYPE) || (k == K_VLENB);
    endfunction

    function automatic logic user_ro(input csr_kind_e k);
        return (k == K_VL) || (k == K_VTYPE) || (k == K_VLENB);
    endfunction

endpackage

// File: rtl/vcsr_decode.sv
module vcsr_decode
    import vcsr_pkg::*;
#(
    parameter bit HAS_FPU = 1'b0
) (
    input  logic        valid,
    input  logic        write,
    input  logic [11:0] addr,
    input  ctx_e        ctx,
    output dec_t        dec
);

    csr_kind_e kind;

    always_comb begin
        case (addr)
            A_VSTART:  kind = K_VSTART;
            A_VXSAT:   kind = K_VXSAT;
            A_VXRM:    kind = K_VXRM;
            A_VL:      kind = K_VL;
            A_VTYPE:   kind = K_VTYPE;
            A_VLENB:   kind = K_VLENB;
            A_FCSR:    kind = HAS_FPU ? K_NONE : K_FCSR;
            A_MSTATUS: kind = K_MSTATUS;
            A_SSTATUS: kind = K_SSTATUS;
            default:   kind = in_vec_range(addr) ? K_BAD : K_NONE;
        endcase
    end

    always_comb begin
        dec.kind    = kind;
        dec.hit     = valid && (kind != K_NONE);
        dec.illegal = dec.hit && ((kind == K_BAD)
                                  || (write && user_ro(kind))
                                  || ((ctx == CTX_OFF) && gated_by_ctx(kind)));
        dec.wr_en   = dec.hit && write && !dec.illegal;
    end

endmodule

// File: rtl/vcsr_ctx.sv
module vcsr_ctx
    import vcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       status_we,
    input  logic [1:0] status_val,
    input  logic       mark_dirty,
    output ctx_e       ctx
);

    ctx_e ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= CTX_OFF;
        end else if (status_we) begin
            ctx_q <= ctx_e'(status_val);
        end else if (mark_dirty && (ctx_q != CTX_OFF)) begin
            ctx_q <= CTX_DIRTY;
        end
    end

    assign ctx = ctx_q;

    assert_status_write_R5: assert property (@(posedge clk) disable iff (rst)
        status_we |=> (ctx_q == ctx_e'($past(status_val))));

    assert_dirty_mark_R8: assert property (@(posedge clk) disable iff (rst)
        (mark_dirty && !status_we && (ctx_q != CTX_OFF)) |=> (ctx_q == CTX_DIRTY));

    assert_off_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ((ctx_q == CTX_OFF) && !status_we) |=> (ctx_q == CTX_OFF));

endmodule

// File: rtl/vcsr_fixpt.sv
module vcsr_fixpt (
    input  logic       clk,
    input  logic       rst,
    input  logic       sat_we,
    input  logic       sat_d,
    input  logic       rm_we,
    input  logic [1:0] rm_d,
    output logic       sat,
    output logic [1:0] rm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sat <= 1'b0;
            rm  <= 2'd0;
        end else begin
            if (sat_we) sat <= sat_d;
            if (rm_we)  rm  <= rm_d;
        end
    end

    assert_rm_load_R7: assert property (@(posedge clk) disable iff (rst)
        rm_we |=> (rm == $past(rm_d)));

    assert_sat_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !sat_we |=> $stable(sat));

endmodule

// File: rtl/vcsr_vcfg.sv
module vcsr_vcfg #(
    parameter int XLEN     = 32,
    parameter int VSTART_W = 7,
    parameter int VL_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vstart_we,
    input  logic [VSTART_W-1:0] vstart_d,
    input  logic                upd_en,
    input  logic [VL_W-1:0]     upd_vl,
    input  logic [XLEN-1:0]     upd_vtype,
    output logic [VSTART_W-1:0] vstart,
    output logic [VL_W-1:0]     vl,
    output logic [XLEN-1:0]     vtype
);

    localparam logic [XLEN-1:0] VTYPE_RST = {1'b1, {(XLEN-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            vstart <= '0;
            vl     <= '0;
            vtype  <= VTYPE_RST;
        end else begin
            if (vstart_we) vstart <= vstart_d;
            if (upd_en) begin
                vl    <= upd_vl;
                vtype <= upd_vtype;
            end
        end
    end

    assert_cfg_load_R9: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> ((vl == $past(upd_vl)) && (vtype == $past(upd_vtype))));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> ($stable(vl) && $stable(vtype)));

endmodule

// File: rtl/vec_csr_unit.sv
module vec_csr_unit
    import vcsr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ELEN    = 32,
    parameter int VLEN    = 128,
    parameter int SLEN    = 128,
    parameter bit HAS_FPU = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [11:0]           req_addr,
    input  logic [XLEN-1:0]       req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_illegal,
    output logic [XLEN-1:0]       rsp_rdata,
    input  logic                  issue_valid,
    output logic                  issue_illegal,
    input  logic                  cfg_valid,
    input  logic [$clog2(VLEN):0] cfg_vl,
    input  logic [XLEN-1:0]       cfg_vtype,
    output logic [1:0]            ctx_status
);

    localparam int VSTART_W = $clog2(VLEN);
    localparam int VL_W     = VSTART_W + 1;
    localparam logic [XLEN-1:0] VLENB_VAL = XLEN'(VLEN / 8);

    initial begin
        assert (is_pow2(ELEN) && is_pow2(VLEN) && is_pow2(SLEN)
                && (VLEN >= SLEN) && (SLEN >= 32) && (VLEN >= ELEN)
                && (XLEN >= 32) && (VL_W <= XLEN))
            else $error("vec_csr_unit: illegal ELEN/VLEN/SLEN/XLEN combination");
    end

    ctx_e                ctx;
    dec_t                dec;
    logic                fx_sat;
    logic [1:0]          fx_rm;
    logic [VSTART_W-1:0] vstart_q;
    logic [VL_W-1:0]     vl_q;
    logic [XLEN-1:0]     vtype_q;
    logic [XLEN-1:0]     rd;
    logic                status_we, fx_dirty, upd_en, mark_dirty;
    logic                sat_we, rm_we, sat_d;
    logic [1:0]          rm_d;
    logic                unused_wdata;

    assign unused_wdata = ^req_wdata;

    vcsr_decode #(.HAS_FPU(HAS_FPU)) u_decode (
        .valid (req_valid),
        .write (req_write),
        .addr  (req_addr),
        .ctx   (ctx),
        .dec   (dec)
    );

    assign status_we  = dec.wr_en && ((dec.kind == K_MSTATUS) || (dec.kind == K_SSTATUS));
    assign fx_dirty   = dec.wr_en && ((dec.kind == K_VSTART) || (dec.kind == K_VXSAT)
                                      || (dec.kind == K_VXRM) || (dec.kind == K_FCSR));
    assign upd_en     = cfg_valid && (ctx != CTX_OFF);
    assign mark_dirty = fx_dirty || upd_en;

    vcsr_ctx u_ctx (
        .clk        (clk),
        .rst        (rst),
        .status_we  (status_we),
        .status_val (req_wdata[CTX_HI:CTX_LO]),
        .mark_dirty (mark_dirty),
        .ctx        (ctx)
    );

    always_comb begin
        sat_we = dec.wr_en && ((dec.kind == K_VXSAT) || (dec.kind == K_FCSR));
        rm_we  = dec.wr_en && ((dec.kind == K_VXRM)  || (dec.kind == K_FCSR));
        sat_d  = (dec.kind == K_FCSR) ? req_wdata[FX_SAT] : req_wdata[0];
        rm_d   = (dec.kind == K_FCSR) ? req_wdata[FX_RM_HI:FX_RM_LO] : req_wdata[1:0];
    end

    vcsr_fixpt u_fixpt (
        .clk    (clk),
        .rst    (rst),
        .sat_we (sat_we),
        .sat_d  (sat_d),
        .rm_we  (rm_we),
        .rm_d   (rm_d),
        .sat    (fx_sat),
        .rm     (fx_rm)
    );

    vcsr_vcfg #(.XLEN(XLEN), .VSTART_W(VSTART_W), .VL_W(VL_W)) u_vcfg (
        .clk       (clk),
        .rst       (rst),
        .vstart_we (dec.wr_en && (dec.kind == K_VSTART)),
        .vstart_d  (req_wdata[VSTART_W-1:0]),
        .upd_en    (upd_en),
        .upd_vl    (cfg_vl),
        .upd_vtype (cfg_vtype),
        .vstart    (vstart_q),
        .vl        (vl_q),
        .vtype     (vtype_q)
    );

    always_comb begin
        rd = '0;
        case (dec.kind)
            K_VSTART:  rd[VSTART_W-1:0] = vstart_q;
            K_VXSAT:   rd[0] = fx_sat;
            K_VXRM:    rd[1:0] = fx_rm;
            K_VL:      rd[VL_W-1:0] = vl_q;
            K_VTYPE:   rd = vtype_q;
            K_VLENB:   rd = VLENB_VAL;
            K_FCSR: begin
                rd[FX_SAT] = fx_sat;
                rd[FX_RM_HI:FX_RM_LO] = fx_rm;
            end
            K_MSTATUS, K_SSTATUS: rd[CTX_HI:CTX_LO] = ctx;
            default:   rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_illegal <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid   <= dec.hit;
            rsp_illegal <= dec.illegal;
            rsp_rdata   <= dec.illegal ? '0 : rd;
        end
    end

    assign issue_illegal = issue_valid && (ctx == CTX_OFF);
    assign ctx_status    = ctx;

    assert_ro_write_illegal_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && ((req_addr == A_VL) || (req_addr == A_VTYPE)
                                    || (req_addr == A_VLENB))) |=> rsp_illegal);

    assert_vlenb_value_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (req_addr == A_VLENB) && (ctx_status != 2'd0))
            |=> (rsp_valid && !rsp_illegal && (rsp_rdata == VLENB_VAL)));

    assert_off_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        ((ctx_status == 2'd0) && !status_we)
            |=> ($stable(vl_q) && $stable(vtype_q) && $stable(vstart_q)));

    assert_vec_range_answers_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_vec_range(req_addr)) |=> rsp_valid);

    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

endmodule

// File: tb/vec_csr_unit_tb.sv
`timescale 1ns/1ps
module vec_csr_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_illegal;
    logic [31:0] rsp_rdata;
    logic        issue_valid = 1'b0, issue_illegal;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_vl = '0;
    logic [31:0] cfg_vtype = '0;
    logic [1:0]  ctx_status;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        ill;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #4 clk = ~clk;

    vec_csr_unit u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata),
        .issue_valid(issue_valid), .issue_illegal(issue_illegal),
        .cfg_valid(cfg_valid), .cfg_vl(cfg_vl), .cfg_vtype(cfg_vtype),
        .ctx_status(ctx_status)
    );

    // monitor: compares each response against the head of the scoreboard
    always @(posedge clk) begin
        #1;
        if (!rst && rsp_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R10/R11 unexpected response ill=%0b data=%h expected none",
                         rsp_illegal, rsp_rdata);
            end else begin
                e = q.pop_front();
                if (rsp_illegal !== e.ill || rsp_rdata !== e.data) begin
                    errors++;
                    $display("FAIL %s actual ill=%0b data=%h expected ill=%0b data=%h",
                             e.tag, rsp_illegal, rsp_rdata, e.ill, e.data);
                end
            end
        end
    end

    task automatic op(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic exp_rsp, input logic ex_ill, input logic [31:0] ex_d,
                      input string tag);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        if (exp_rsp) q.push_back('{ex_ill, ex_d, tag});
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic cfg_only(input logic [7:0] vl, input logic [31:0] vt);
        cfg_valid = 1'b1; cfg_vl = vl; cfg_vtype = vt;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_issue(input logic exp, input string tag);
        issue_valid = 1'b1;
        #1;
        chk({31'd0, issue_illegal}, {31'd0, exp}, tag);
        issue_valid = 1'b0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk({30'd0, ctx_status}, 32'd0, "R1 ctx after reset");
        op(0, 12'h009, 0, 1, 0, 32'd0, "R1 vxsat reset");
        op(0, 12'hC20, 0, 1, 1, 32'd0, "R6 vl read while Off");
        chk_issue(1'b1, "R6 issue while Off");
        op(0, 12'h300, 0, 1, 0, 32'd0, "R5 mstatus reset");
        op(1, 12'h008, 32'd9, 1, 1, 32'd0, "R6 vstart write while Off");
        cfg_only(8'd50, 32'h5);

        // enable through supervisor view
        op(1, 12'h100, 32'h0080_0000, 1, 0, 32'd0, "R5 sstatus write old value");
        chk({30'd0, ctx_status}, 32'd1, "R5 ctx Initial");
        op(0, 12'h300, 0, 1, 0, 32'h0080_0000, "R5 mstatus mirrors sstatus");
        op(0, 12'hC20, 0, 1, 0, 32'd0, "R1 R9 vl reset, Off update ignored");
        op(0, 12'hC21, 0, 1, 0, 32'h8000_0000, "R1 vtype reset");
        op(0, 12'h008, 0, 1, 0, 32'd0, "R6 vstart untouched while Off");
        chk({30'd0, ctx_status}, 32'd1, "R8 reads keep Initial");
        chk_issue(1'b0, "R6 issue while Initial");
        op(0, 12'hC22, 0, 1, 0, 32'd16, "R4 vlenb");

        // fixed-point registers
        op(1, 12'h00A, 32'hFFFF_FFFF, 1, 0, 32'd0, "R11 vxrm write returns old");
        op(0, 12'h00A, 0, 1, 0, 32'd3, "R2 vxrm 2 bits");
        chk({30'd0, ctx_status}, 32'd3, "R8 Dirty after vxrm write");
        op(1, 12'h300, 32'h0100_0000, 1, 0, 32'h0180_0000, "R5 mstatus write old Dirty");
        chk({30'd0, ctx_status}, 32'd2, "R5 ctx Clean");
        op(1, 12'h009, 32'hFFFF_FFFE, 1, 0, 32'd0, "R2 vxsat write");
        op(0, 12'h009, 0, 1, 0, 32'd0, "R2 vxsat keeps bit 0 only");
        chk({30'd0, ctx_status}, 32'd3, "R8 Dirty after vxsat write");
        op(1, 12'h009, 32'd1, 1, 0, 32'd0, "R2 vxsat write 1");
        op(0, 12'h009, 0, 1, 0, 32'd1, "R2 vxsat reads 1");

        // mirrored view
        op(0, 12'h003, 0, 1, 0, 32'h0000_0700, "R7 fcsr read");
        op(1, 12'h003, 32'h0000_0200, 1, 0, 32'h0000_0700, "R7 fcsr write old");
        op(0, 12'h00A, 0, 1, 0, 32'd1, "R7 vxrm via fcsr");
        op(0, 12'h009, 0, 1, 0, 32'd0, "R7 vxsat via fcsr");

        // start index width
        op(1, 12'h008, 32'hFFFF_FFFF, 1, 0, 32'd0, "R2 vstart write");
        op(0, 12'h008, 0, 1, 0, 32'h7F, "R2 vstart truncated");

        // read-only registers
        op(1, 12'hC20, 32'd5, 1, 1, 32'd0, "R3 vl write illegal");
        op(1, 12'hC21, 32'd5, 1, 1, 32'd0, "R3 vtype write illegal");
        op(1, 12'hC22, 32'd5, 1, 1, 32'd0, "R3 vlenb write illegal");
        op(0, 12'hC20, 0, 1, 0, 32'd0, "R3 vl unchanged");
        op(0, 12'hC21, 0, 1, 0, 32'h8000_0000, "R3 vtype unchanged");

        // configuration updates
        op(1, 12'h300, 32'h0100_0000, 1, 0, 32'h0180_0000, "R5 back to Clean");
        cfg_only(8'd9, 32'h0000_000D);
        chk({30'd0, ctx_status}, 32'd3, "R8 Dirty after update");
        op(0, 12'hC20, 0, 1, 0, 32'd9, "R9 vl loaded");
        op(0, 12'hC21, 0, 1, 0, 32'h0000_000D, "R9 vtype loaded");
        cfg_valid = 1'b1; cfg_vl = 8'd4; cfg_vtype = 32'h11;
        op(1, 12'h008, 32'd3, 1, 0, 32'h7F, "R9 vstart write with update");
        cfg_valid = 1'b0;
        op(0, 12'hC20, 0, 1, 0, 32'd4, "R9 vl with concurrent write");
        op(0, 12'h008, 0, 1, 0, 32'd3, "R9 vstart with concurrent update");
        cfg_valid = 1'b1; cfg_vl = 8'd6; cfg_vtype = 32'h22;
        op(1, 12'h300, 32'h0100_0000, 1, 0, 32'h0180_0000, "R8 status write with update");
        cfg_valid = 1'b0;
        chk({30'd0, ctx_status}, 32'd2, "R8 status write wins");
        op(0, 12'hC21, 0, 1, 0, 32'h22, "R9 vtype with status write");

        // unimplemented and foreign addresses
        op(0, 12'h00B, 0, 1, 1, 32'd0, "R10 0x00B");
        op(0, 12'h00F, 0, 1, 1, 32'd0, "R10 0x00F");
        op(0, 12'hC23, 0, 1, 1, 32'd0, "R10 0xC23");
        op(0, 12'h7C0, 0, 0, 0, 32'd0, "R10 foreign");
        op(0, 12'h009, 0, 1, 0, 32'd0, "R10 order kept after foreign");

        // back to Off
        op(1, 12'h300, 32'd0, 1, 0, 32'h0100_0000, "R5 mstatus Off");
        chk({30'd0, ctx_status}, 32'd0, "R6 ctx Off");
        chk_issue(1'b1, "R6 issue while Off again");
        op(0, 12'h008, 0, 1, 1, 32'd0, "R6 vstart read while Off");
        op(1, 12'h008, 32'd5, 1, 1, 32'd0, "R6 vstart write while Off");
        op(0, 12'hC22, 0, 1, 1, 32'd0, "R6 vlenb while Off");
        cfg_only(8'd7, 32'h33);
        op(1, 12'h00A, 32'd2, 1, 0, 32'd1, "R8 vxrm write while Off");
        chk({30'd0, ctx_status}, 32'd0, "R8 stays Off");
        op(1, 12'h100, 32'h0080_0000, 1, 0, 32'd0, "R5 sstatus enable");
        op(0, 12'h008, 0, 1, 0, 32'd3, "R6 vstart unchanged");
        op(0, 12'hC20, 0, 1, 0, 32'd6, "R9 Off update ignored");
        op(0, 12'h00A, 0, 1, 0, 32'd2, "R8 vxrm written while Off");

        repeat (3) @(negedge clk);
        chk(q.size(), 32'd0, "R11 all responses arrived");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule